// File: doc/BRIEF.md
# Stop-Mode Wake-Up Clock Sequencer

This block decides how a small microcontroller comes back from its clock-stopped low-power state. While the core is stopped, the block watches four things: an external interrupt wake request, the external reset pin, a brownout comparator flag and the watchdog reset. It then chooses one of two ways to restart the clock. In the first, the crystal is re-enabled and the core is held until the oscillator has had a full warm-up count of crystal ticks. In the second, the core runs at once from an internal ring oscillator while the crystal warms up in the background. When the count finishes, the clock moves over to the crystal through a break-before-make gate handover.

The block also raises a reset request for any reset-caused exit. It drives a vector selector that tells the core whether to fetch from address 0000h or from the interrupt vector. Two configuration bits set the behaviour: one selects ring-oscillator wake-up and one enables brownout detection during stop. The analog oscillators and the comparator are outside the block. The crystal appears only as a one-cycle tick strobe (`xtalTick`), and the brownout comparator appears as a level input.

Top module: `wake_seq`

## Requirements
- R1: A crystal warm-up holds `cpuRun` low until `2**WARM_BITS` crystal ticks have been counted (65,536 at the default width). `cpuRun` rises at the clock edge that takes the final tick. A crystal warm-up happens on an interrupt wake with `cfgRingSel`=0 or with `HAS_RING`=0, and on every reset-caused exit from stop.
- R2: With `HAS_RING`=1 and `cfgRingSel`=1, an interrupt wake from stop drives `cpuRun`=1 and `ringGate`=1 from the first edge after the wake.
- R3: During a ring wake, `ringGate` stays 1 for `2**WARM_BITS` crystal ticks. It falls at the edge of the final tick, and `xtalGate` rises one edge later. `ringGate` and `xtalGate` are never 1 together, and `cpuRun` is 0 in the single gap cycle between them. `ringGate`=1 also reports that the core is running from the ring oscillator.
- R4: `wdogRst` has no effect while stopped: the core stays halted and `rstReq` stays 0. While running, `wdogRst` pulses `rstReq` and sets `vecSel` to 0.
- R5: `extRst` in stop always exits stop, whatever the two configuration bits hold. The exit is a one-cycle `rstReq`=1 pulse, `vecSel`=0 and a crystal warm-up.
- R6: `brownout` in stop causes a reset exit, as in R5, only when `cfgBgEn`=1. With `cfgBgEn`=0 the core stays halted and `rstReq` stays 0.
- R7: `vecSel`=0 selects the 0000h reset vector and is set by every reset-caused exit. `vecSel`=1 selects the interrupt vector and is set by every interrupt-caused exit.
- R8: While `rstN` is low, `rstReq`=1, `vecSel`=0 and `cpuRun`=0. After `rstN` is released, a full crystal warm-up runs regardless of `cfgBgEn`.
- R9: The warm-up counter is cleared on every entry into stop. A wake after a stop that interrupted a partly finished count still waits the full count.
- R10: If a reset cause and `wakeIrq` arrive in stop in the same cycle, the reset wins: `rstReq` pulses, `vecSel`=0 and the exit uses a crystal warm-up even when `cfgRingSel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| stopReq | input | 1 | Core requests entry to stop mode |
| wakeIrq | input | 1 | External interrupt wake request |
| extRst | input | 1 | External reset pin, active high |
| wdogRst | input | 1 | Watchdog reset request |
| brownout | input | 1 | Supply below threshold flag |
| cfgRingSel | input | 1 | 1 = wake from the ring oscillator |
| cfgBgEn | input | 1 | 1 = brownout reset active in stop |
| xtalTick | input | 1 | One-cycle strobe per crystal cycle |
| cpuRun | output | 1 | Core clock enable |
| rstReq | output | 1 | Reset request to the core |
| vecSel | output | 1 | 0 = reset vector 0000h, 1 = interrupt vector |
| ringGate | output | 1 | Ring oscillator drives the core clock |
| xtalGate | output | 1 | Crystal drives the core clock |

## Verification
Properties are checked on every cycle. They cover the exclusive clock gates, the counter clearing on stop entry, the watchdog and gated-brownout being ignored in stop, the unconditional pin-reset exit, reset priority over interrupts, and an immediate `cpuRun` on a ring wake. Only the bench scenarios can show the exact cycle at which the warm-up ends, the order of the handover across its gap cycle, the restart of a count that was cut short, and the reset-vector and warm-up path after power-on.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_STOP,
    ST_WARM,
    ST_RING,
    ST_SWAP
  } seq_state_t;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic cntClr;
    logic cntEn;
    logic xtalOn;
    logic xtalOff;
    logic ringOn;
    logic ringOff;
    logic pulseRst;
    logic setVecRst;
    logic setVecIrq;
  } wake_strb_t;

endpackage

// File: rtl/wake_seq_ctrl.sv
module wake_seq_ctrl
  import wake_seq_pkg::*;
#(
  parameter bit HAS_RING = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopReq,
  input  logic       wakeIrq,
  input  logic       extRst,
  input  logic       wdogRst,
  input  logic       brownout,
  input  logic       cfgRingSel,
  input  logic       cfgBgEn,
  input  logic       termHit,
  output wake_strb_t strb,
  output logic       cpuRun
);

  localparam bit RingOk = HAS_RING;

  seq_state_t state, nxt;
  logic stopRstCause;
  logic runRstCause;

  // In stop no timer runs, so the watchdog is not a cause there.
  assign stopRstCause = extRst | (brownout & cfgBgEn);
  assign runRstCause  = extRst | wdogRst;

  always_comb begin
    nxt  = state;
    strb = '0;
    unique case (state)
      ST_RUN: begin
        if (runRstCause) begin
          strb.pulseRst  = 1'b1;
          strb.setVecRst = 1'b1;
        end else if (stopReq) begin
          strb.cntClr  = 1'b1;
          strb.xtalOff = 1'b1;
          nxt          = ST_STOP;
        end
      end
      ST_STOP: begin
        if (stopRstCause) begin
          strb.pulseRst  = 1'b1;
          strb.setVecRst = 1'b1;
          strb.xtalOn    = 1'b1;
          nxt            = ST_WARM;
        end else if (wakeIrq) begin
          strb.setVecIrq = 1'b1;
          if (RingOk && cfgRingSel) begin
            strb.ringOn = 1'b1;
            nxt         = ST_RING;
          end else begin
            strb.xtalOn = 1'b1;
            nxt         = ST_WARM;
          end
        end
      end
      ST_WARM: begin
        strb.cntEn = 1'b1;
        if (extRst) begin
          strb.pulseRst  = 1'b1;
          strb.setVecRst = 1'b1;
        end
        if (termHit) nxt = ST_RUN;
      end
      ST_RING: begin
        strb.cntEn = 1'b1;
        if (runRstCause) begin
          strb.pulseRst  = 1'b1;
          strb.setVecRst = 1'b1;
        end
        if (stopReq && !runRstCause) begin
          strb.cntClr  = 1'b1;
          strb.ringOff = 1'b1;
          nxt          = ST_STOP;
        end else if (termHit) begin
          strb.ringOff = 1'b1;
          nxt          = ST_SWAP;
        end
      end
      ST_SWAP: begin
        strb.xtalOn = 1'b1;
        nxt         = ST_RUN;
      end
      default: nxt = ST_WARM;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WARM;
    else       state <= nxt;
  end

  assign cpuRun = (state == ST_RUN) || (state == ST_RING);

  // R4: watchdog alone cannot end stop
  p_wdog_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && wdogRst && !stopRstCause && !wakeIrq) |=> (state == ST_STOP));

  // R5: pin reset always leaves stop into a warm-up
  p_pin_exit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && extRst) |=> (state == ST_WARM && !cpuRun));

  // R6: brownout with detection disabled is ignored
  p_bg_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && brownout && !cfgBgEn && !extRst && !wakeIrq) |=> (state == ST_STOP));

  // R10: reset beats a simultaneous interrupt
  p_rst_prio_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && stopRstCause && wakeIrq) |=> (state == ST_WARM));

  // R2: ring wake runs the core on the next cycle
  p_ring_now_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && wakeIrq && !stopRstCause && cfgRingSel && RingOk) |=> cpuRun);

endmodule

// File: rtl/wake_seq_dp.sv
module wake_seq_dp
  import wake_seq_pkg::*;
#(
  parameter int unsigned WARM_BITS = 16,
  parameter bit          HAS_RING  = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  wake_strb_t strb,
  input  logic       xtalTick,
  output logic       termHit,
  output logic       rstReq,
  output logic       vecSel,
  output logic       ringGate,
  output logic       xtalGate
);

  localparam logic [WARM_BITS-1:0] CntMax = {WARM_BITS{1'b1}};

  logic [WARM_BITS-1:0] warmCnt;

  // Terminal count: the tick that wraps the counter from all ones.
  assign termHit = strb.cntEn && xtalTick && (warmCnt == CntMax);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        warmCnt <= '0;
    else if (strb.cntClr)             warmCnt <= '0;
    else if (strb.cntEn && xtalTick)  warmCnt <= warmCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstReq <= 1'b1;
      vecSel <= 1'b0;
    end else begin
      rstReq <= strb.pulseRst;
      if (strb.setVecRst)      vecSel <= 1'b0;
      else if (strb.setVecIrq) vecSel <= 1'b1;
    end
  end

  // Crystal gate: on during power-on warm-up, closed in stop.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             xtalGate <= 1'b1;
    else if (strb.xtalOff) xtalGate <= 1'b0;
    else if (strb.xtalOn)  xtalGate <= 1'b1;
  end

  generate
    if (HAS_RING) begin : g_ring
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             ringGate <= 1'b0;
        else if (strb.ringOff) ringGate <= 1'b0;
        else if (strb.ringOn)  ringGate <= 1'b1;
      end
    end else begin : g_no_ring
      assign ringGate = 1'b0;
    end
  endgenerate

  // R3: the two clock gates never overlap
  p_gates_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(ringGate && xtalGate));

  // R3: crystal takes over only after the ring gate was already closed
  p_break_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ringGate && strb.ringOff) |=> (!ringGate && !xtalGate));

  // R9: counter is zero after a stop entry
  p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntClr |=> (warmCnt == '0));

  // R7: every reset pulse points at the reset vector
  p_rst_vec_r7: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> !vecSel);

endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import wake_seq_pkg::*;
#(
  parameter int unsigned WARM_BITS = 16,
  parameter bit          HAS_RING  = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic stopReq,
  input  logic wakeIrq,
  input  logic extRst,
  input  logic wdogRst,
  input  logic brownout,
  input  logic cfgRingSel,
  input  logic cfgBgEn,
  input  logic xtalTick,
  output logic cpuRun,
  output logic rstReq,
  output logic vecSel,
  output logic ringGate,
  output logic xtalGate
);

  wake_strb_t strb;
  logic       termHit;

  wake_seq_ctrl #(.HAS_RING(HAS_RING)) u_ctrl (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .wakeIrq(wakeIrq),
    .extRst(extRst), .wdogRst(wdogRst), .brownout(brownout),
    .cfgRingSel(cfgRingSel), .cfgBgEn(cfgBgEn), .termHit(termHit),
    .strb(strb), .cpuRun(cpuRun)
  );

  wake_seq_dp #(.WARM_BITS(WARM_BITS), .HAS_RING(HAS_RING)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .xtalTick(xtalTick),
    .termHit(termHit), .rstReq(rstReq), .vecSel(vecSel),
    .ringGate(ringGate), .xtalGate(xtalGate)
  );

endmodule

// File: tb/wake_seq_tb.sv
`timescale 1ns/1ps
module wake_seq_tb;

  localparam int WB   = 8;
  localparam int NTCK = 1 << WB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopReq = 0, wakeIrq = 0, extRst = 0, wdogRst = 0, brownout = 0;
  logic cfgRingSel = 0, cfgBgEn = 0, xtalTick = 1'b1;
  logic cpuRun, rstReq, vecSel, ringGate, xtalGate;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  wake_seq #(.WARM_BITS(WB), .HAS_RING(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .wakeIrq(wakeIrq),
    .extRst(extRst), .wdogRst(wdogRst), .brownout(brownout),
    .cfgRingSel(cfgRingSel), .cfgBgEn(cfgBgEn), .xtalTick(xtalTick),
    .cpuRun(cpuRun), .rstReq(rstReq), .vecSel(vecSel),
    .ringGate(ringGate), .xtalGate(xtalGate)
  );

  // Fields: [9]ringSel [8]bgEn [7]irq [6]ext [5]bo [4]wd
  //         [3]expWake [2]expRing [1]expRst [0]expVec
  localparam logic [9:0] VEC [8] = '{
    10'b00_1000_1001,  // R1 R7 irq, crystal warm-up
    10'b10_1000_1101,  // R2 irq, ring wake
    10'b00_0100_1010,  // R5 pin reset
    10'b11_0100_1010,  // R5 pin reset, other config
    10'b01_0010_1010,  // R6 brownout enabled
    10'b10_0010_0000,  // R6 brownout disabled
    10'b11_0001_0000,  // R4 watchdog in stop
    10'b10_1100_1010   // R10 reset beats irq
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called just after the wake edge; full crystal warm-up follows.
  task automatic finishWarm(input string req);
    for (int i = 0; i < NTCK - 1; i++) begin
      step();
      if (i == 0) chk({req, " rstReq one cycle"}, rstReq, 0);
    end
    chk({req, " held before last tick"}, cpuRun, 0);
    step();
    chk({req, " runs after last tick"}, cpuRun, 1);
    chk({req, " crystal gate"}, xtalGate, 1);
  endtask

  // Called just after a ring wake edge (R3).
  task automatic finishRing();
    for (int i = 0; i < NTCK - 1; i++) step();
    chk("R3 ring still on", ringGate, 1);
    chk("R3 crystal still off", xtalGate, 0);
    step();
    chk("R3 ring off at terminal", ringGate, 0);
    chk("R3 crystal off in gap", xtalGate, 0);
    chk("R3 cpu paused in gap", cpuRun, 0);
    step();
    chk("R3 crystal on", xtalGate, 1);
    chk("R3 cpu runs on crystal", cpuRun, 1);
  endtask

  task automatic enterStop();
    stopReq = 1'b1;
    step();
    stopReq = 1'b0;
    chk("R1 halted in stop", cpuRun, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    // R8 power-on state and warm-up
    step(); step();
    chk("R8 rstReq during reset", rstReq, 1);
    chk("R8 vecSel during reset", vecSel, 0);
    chk("R8 cpuRun during reset", cpuRun, 0);
    rstN = 1'b1;
    finishWarm("R8");

    // R4 watchdog while running
    wdogRst = 1'b1;
    step();
    wdogRst = 1'b0;
    chk("R4 run wdog rstReq", rstReq, 1);
    chk("R4 run wdog vecSel", vecSel, 0);
    step();

    for (int i = 0; i < 8; i++) begin
      logic [9:0] v;
      v = VEC[i];
      enterStop();
      cfgRingSel = v[9]; cfgBgEn = v[8];
      wakeIrq = v[7]; extRst = v[6]; brownout = v[5]; wdogRst = v[4];
      step();
      wakeIrq = 0; extRst = 0; brownout = 0; wdogRst = 0;
      chk($sformatf("R1 R2 vec%0d cpuRun", i), cpuRun, int'(v[2]));
      chk($sformatf("R2 vec%0d ringGate", i), ringGate, int'(v[2]));
      chk($sformatf("R5 R10 vec%0d rstReq", i), rstReq, int'(v[1]));
      if (v[3]) chk($sformatf("R7 vec%0d vecSel", i), vecSel, int'(v[0]));
      if (!v[3]) begin
        step(); step();
        chk($sformatf("R4 R6 vec%0d still halted", i), cpuRun, 0);
        chk($sformatf("R4 R6 vec%0d no reset", i), rstReq, 0);
        cfgRingSel = 1'b0;
        wakeIrq = 1'b1;
        step();
        wakeIrq = 1'b0;
        finishWarm("R1 exit");
      end else if (v[2]) begin
        finishRing();
      end else begin
        finishWarm($sformatf("R1 vec%0d", i));
      end
      step();
    end

    // R9 partial ring count, stop, then a full crystal warm-up
    enterStop();
    cfgRingSel = 1'b1;
    wakeIrq = 1'b1;
    step();
    wakeIrq = 1'b0;
    for (int i = 0; i < 100; i++) step();
    chk("R9 ring running", ringGate, 1);
    enterStop();
    chk("R9 ring closed in stop", ringGate, 0);
    cfgRingSel = 1'b0;
    wakeIrq = 1'b1;
    step();
    wakeIrq = 1'b0;
    finishWarm("R9");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule